// File: doc/BRIEF.md
# Masked Interrupt Status Aggregator

This block gathers event pulses from several serial-bus channel engines and turns them into one interrupt request. Each channel owns a status word and an enable word. When a channel reports one or more events in a cycle, its status is re-evaluated: the new events are merged in and the result is ANDed with the enable word. Any status bit whose enable is clear is removed, not just hidden. A non-zero result sets that channel's bit in a global summary word. The interrupt line is the registered OR of the summary word.

Software writes a channel's enable word, and clears status bits with write-one-to-clear strobes. A clear that leaves a channel's status at zero removes that channel's summary bit. When software clears the receive-complete flag while it is set, and the channel's engine has a receive command waiting, the block pulses a continue request back to that engine. The engine then fetches the next byte and reports a fresh event.

Event flag positions within a channel word are: bit 0 byte acknowledged, bit 1 byte not acknowledged, bit 2 receive complete, bit 3 arbitration lost, bit 4 normal stop, bit 5 abnormal stop, bit 6 clock-line timeout, bit 13 recovery finished, bit 14 data-line timeout, bit 15 target inactivity timeout. Register address decoding and the channel engines are outside this block.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every status word, enable word, summary bit, the interrupt line and every continue pulse are zero.
- R2: An enable write to channel b stores `wdata_i[14:0]` in that channel's enable word, visible on `en_o` one cycle later. Events arriving in the same cycle are masked with the old enable value.
- R3: In a cycle where channel b reports any event, its status one cycle later equals (old status after any clear, OR the events) AND the enable word (bit 15 of the enable is always 0). Disabled events, and held bits whose enable has since been cleared, are dropped. A bit 15 event therefore never appears in status.
- R4: When that evaluation is non-zero, summary bit b is 1 in the same cycle as the new status, and `irq_o` is 1 in that same cycle.
- R5: A clear strobe for channel b clears each status bit whose `wdata_i` bit (positions 0 to 14) is 1, one cycle later. Bits written 0 are kept.
- R6: A clear that leaves channel b's status all zero clears summary bit b. `irq_o` falls in the same cycle once no summary bit remains.
- R7: If an enabled event and a clear of the same bit arrive in the same cycle, the bit is 1 afterwards.
- R8: A clear strobe with `wdata_i[2]`=1, while status bit 2 (receive complete) is 1 and `rx_pend_i[b]` is 1, produces a one-cycle `rx_cont_o[b]` pulse in the next cycle. If any of the three conditions is missing, there is no pulse.
- R9: Channels are independent: summary bit b reflects only channel b, and one channel's strobes never change another channel's state.
- R10: An event evaluation that yields zero status, with no clear in the same cycle, leaves summary bit b unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | NUM_BUS*16 | Event pulses, channel b in bits [16b+15:16b] |
| en_wr_i | input | NUM_BUS | Enable-word write strobe per channel |
| clr_i | input | NUM_BUS | Write-one-to-clear strobe per channel |
| wdata_i | input | 16 | Shared write data for enable writes and clears |
| rx_pend_i | input | NUM_BUS | Receive command waiting in channel engine |
| sts_o | output | NUM_BUS*16 | Status words, same packing as evt_i |
| en_o | output | NUM_BUS*15 | Enable words, channel b in bits [15b+14:15b] |
| glb_o | output | NUM_BUS | Summary word, one bit per channel |
| irq_o | output | 1 | Interrupt request |
| rx_cont_o | output | NUM_BUS | Continue-receive pulse per channel |

## Verification
A wrong status bit shows on `sts_o` in the cycle after the event or clear that caused it. Because the summary bit and the interrupt line are derived in the same cycle, a stale summary bit shows as `irq_o` staying high after the last clear, or failing to rise after an enabled event. A bad continue condition shows within one cycle as a missing or extra `rx_cont_o` pulse. Every output is compared each cycle against a bench model, so a divergence is caught on the first cycle it becomes visible.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
   localparam int FLAG_W        = 16;
   localparam int MASK_W        = 15;
   localparam int F_ACK         = 0;
   localparam int F_NAK         = 1;
   localparam int F_RXDONE      = 2;
   localparam int F_ARB_LOST    = 3;
   localparam int F_STOP_OK     = 4;
   localparam int F_STOP_BAD    = 5;
   localparam int F_CLK_TMO     = 6;
   localparam int F_RECOV_DONE  = 13;
   localparam int F_DATA_TMO    = 14;
   localparam int F_TGT_TMO     = 15;
endpackage

// File: rtl/irqagg_slice.sv
module irqagg_slice #(
   parameter int FLAG_W = 16,
   parameter int EN_W   = 15,
   parameter int CLR_W  = 15,
   parameter int RXD    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [FLAG_W-1:0] evt_i,
   input  logic              en_wr_i,
   input  logic              clr_i,
   input  logic [FLAG_W-1:0] wdata_i,
   input  logic              rx_pend_i,
   output logic [FLAG_W-1:0] sts_o,
   output logic [EN_W-1:0]   en_o,
   output logic              glb_o,
   output logic              glb_nxt_o,
   output logic              rx_cont_o
);
   generate
      if (EN_W > FLAG_W || CLR_W > FLAG_W || RXD >= CLR_W)
         $error("irqagg_slice: bad width parameters");
   endgenerate

   logic [FLAG_W-1:0] sts_q, sts_nxt, en_ext, clr_mask, kept;
   logic [EN_W-1:0]   en_q;
   logic              glb_q, glb_nxt, glb_after_clr, hit, cont_q;

   always_comb begin
      en_ext               = '0;
      en_ext[EN_W-1:0]     = en_q;
      clr_mask             = '0;
      clr_mask[CLR_W-1:0]  = wdata_i[CLR_W-1:0] & {CLR_W{clr_i}};
      kept                 = sts_q & ~clr_mask;
      hit                  = |evt_i;
      sts_nxt              = hit ? ((kept | evt_i) & en_ext) : kept;
      glb_after_clr        = (clr_i && kept == '0) ? 1'b0 : glb_q;
      glb_nxt              = (hit && sts_nxt != '0) ? 1'b1 : glb_after_clr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sts_q  <= '0;
         en_q   <= '0;
         glb_q  <= 1'b0;
         cont_q <= 1'b0;
      end else begin
         sts_q  <= sts_nxt;
         glb_q  <= glb_nxt;
         cont_q <= clr_i & wdata_i[RXD] & sts_q[RXD] & rx_pend_i;
         if (en_wr_i) en_q <= wdata_i[EN_W-1:0];
      end
   end

   assign sts_o     = sts_q;
   assign en_o      = en_q;
   assign glb_o     = glb_q;
   assign glb_nxt_o = glb_nxt;
   assign rx_cont_o = cont_q;

   // R3: after an evaluation no status bit lies outside the old enable word
   p_masked_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_i) |=> ((sts_q & ~FLAG_W'($past(en_q))) == '0));

   // R7: every enabled event bit is present next cycle, even under a clear
   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_i) |=> ((($past(evt_i) & FLAG_W'($past(en_q))) & ~sts_q) == '0));

   // R4: non-zero status always has its summary bit raised
   p_glb_cover_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_q != '0) |-> glb_q);

   // R8: a continue pulse needs a clear of a held receive flag with a pending receive
   p_cont_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_cont_o |-> $past(clr_i && wdata_i[RXD] && sts_q[RXD] && rx_pend_i));

   // R5: a clear alone never sets a status bit
   p_clr_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !(|evt_i)) |=> ((sts_q & ~$past(sts_q)) == '0));
endmodule

// File: rtl/irqagg_line.sv
module irqagg_line #(
   parameter int NUM_BUS = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_BUS-1:0] glb_nxt_i,
   input  logic [NUM_BUS-1:0] glb_i,
   output logic               irq_o
);
   logic irq_q;

   always_ff @(posedge clk) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |glb_nxt_i;
   end

   assign irq_o = irq_q;

   // R6: the line is low whenever no summary bit is held
   p_irq_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (glb_i == '0) |-> !irq_o);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
   parameter int NUM_BUS = 4,
   parameter int FLAG_W  = irqagg_pkg::FLAG_W,
   parameter int EN_W    = irqagg_pkg::MASK_W
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_BUS*FLAG_W-1:0] evt_i,
   input  logic [NUM_BUS-1:0]        en_wr_i,
   input  logic [NUM_BUS-1:0]        clr_i,
   input  logic [FLAG_W-1:0]         wdata_i,
   input  logic [NUM_BUS-1:0]        rx_pend_i,
   output logic [NUM_BUS*FLAG_W-1:0] sts_o,
   output logic [NUM_BUS*EN_W-1:0]   en_o,
   output logic [NUM_BUS-1:0]        glb_o,
   output logic                      irq_o,
   output logic [NUM_BUS-1:0]        rx_cont_o
);
   localparam int CLR_W = EN_W;

   generate
      if (NUM_BUS < 1) $error("irq_aggregator: NUM_BUS must be positive");
   endgenerate

   logic [NUM_BUS-1:0] glb_nxt;

   for (genvar b = 0; b < NUM_BUS; b++) begin : g_bus
      irqagg_slice #(
         .FLAG_W (FLAG_W),
         .EN_W   (EN_W),
         .CLR_W  (CLR_W),
         .RXD    (irqagg_pkg::F_RXDONE)
      ) u_slice (
         .clk       (clk),
         .rst_n     (rst_n),
         .evt_i     (evt_i[b*FLAG_W +: FLAG_W]),
         .en_wr_i   (en_wr_i[b]),
         .clr_i     (clr_i[b]),
         .wdata_i   (wdata_i),
         .rx_pend_i (rx_pend_i[b]),
         .sts_o     (sts_o[b*FLAG_W +: FLAG_W]),
         .en_o      (en_o[b*EN_W +: EN_W]),
         .glb_o     (glb_o[b]),
         .glb_nxt_o (glb_nxt[b]),
         .rx_cont_o (rx_cont_o[b])
      );
   end

   irqagg_line #(.NUM_BUS(NUM_BUS)) u_line (
      .clk       (clk),
      .rst_n     (rst_n),
      .glb_nxt_i (glb_nxt),
      .glb_i     (glb_o),
      .irq_o     (irq_o)
   );

   // R4: the line only rises after some channel reported an event
   p_irq_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_o) |-> $past(|evt_i));

   // R9: a channel's summary bit only rises when that channel had events
   for (genvar b = 0; b < NUM_BUS; b++) begin : g_chk
      p_own_bit_r9: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(glb_o[b]) |-> $past(|evt_i[b*FLAG_W +: FLAG_W]));
   end
endmodule

// File: tb/sim_irq_aggregator.sv
module sim_irq_aggregator;
   localparam int NB = 4;
   localparam int FW = 16;
   localparam int EW = 15;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NB*FW-1:0] evt_i = '0;
   logic [NB-1:0]   en_wr_i = '0, clr_i = '0, rx_pend_i = '0;
   logic [FW-1:0]   wdata_i = '0;
   logic [NB*FW-1:0] sts_o;
   logic [NB*EW-1:0] en_o;
   logic [NB-1:0]   glb_o, rx_cont_o;
   logic            irq_o;

   always #10 clk = ~clk;   // 50 MHz

   irq_aggregator #(.NUM_BUS(NB)) u0 (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i), .en_wr_i(en_wr_i),
      .clr_i(clr_i), .wdata_i(wdata_i), .rx_pend_i(rx_pend_i),
      .sts_o(sts_o), .en_o(en_o), .glb_o(glb_o), .irq_o(irq_o),
      .rx_cont_o(rx_cont_o));

   typedef struct {
      logic [NB*FW-1:0] sts;
      logic [NB*EW-1:0] en;
      logic [NB-1:0]    glb;
      logic             irq;
      logic [NB-1:0]    cont;
      string            tag;
   } exp_t;

   exp_t q[$];
   int n_chk = 0, n_bad = 0;
   bit done = 0;

   logic [FW-1:0] m_sts [NB];
   logic [EW-1:0] m_en  [NB];
   logic [NB-1:0] m_glb;

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   // driver: applies one cycle of stimulus and queues the expected result
   task automatic cyc(input string tag, input logic [NB*FW-1:0] evt,
                      input logic [NB-1:0] enw, input logic [NB-1:0] clr,
                      input logic [FW-1:0] wd, input logic [NB-1:0] pend);
      exp_t e;
      @(negedge clk); #1;
      evt_i = evt; en_wr_i = enw; clr_i = clr; wdata_i = wd; rx_pend_i = pend;
      for (int b = 0; b < NB; b++) begin
         logic [FW-1:0] ev, cm, kept, ns, enx;
         logic g;
         ev   = evt[b*FW +: FW];
         cm   = clr[b] ? (wd & 16'h7FFF) : 16'h0;
         kept = m_sts[b] & ~cm;
         enx  = {1'b0, m_en[b]};
         ns   = (ev != 0) ? ((kept | ev) & enx) : kept;
         g    = (clr[b] && kept == 0) ? 1'b0 : m_glb[b];
         if (ev != 0 && ns != 0) g = 1'b1;
         e.cont[b] = clr[b] & wd[2] & m_sts[b][2] & pend[b];
         m_sts[b] = ns;
         m_glb[b] = g;
         if (enw[b]) m_en[b] = wd[EW-1:0];
      end
      for (int b = 0; b < NB; b++) begin
         e.sts[b*FW +: FW] = m_sts[b];
         e.en[b*EW +: EW]  = m_en[b];
      end
      e.glb = m_glb;
      e.irq = |m_glb;
      e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: compares queued expectations one cycle after they were driven
   initial begin
      forever begin
         @(negedge clk);
         if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            for (int b = 0; b < NB; b++) begin
               chk(sts_o[b*FW +: FW] == e.sts[b*FW +: FW], e.tag, $sformatf("sts%0d", b),
                   64'(sts_o[b*FW +: FW]), 64'(e.sts[b*FW +: FW]));
               chk(en_o[b*EW +: EW] == e.en[b*EW +: EW], e.tag, $sformatf("en%0d", b),
                   64'(en_o[b*EW +: EW]), 64'(e.en[b*EW +: EW]));
            end
            chk(glb_o == e.glb, e.tag, "glb", 64'(glb_o), 64'(e.glb));
            chk(irq_o == e.irq, e.tag, "irq", 64'(irq_o), 64'(e.irq));
            chk(rx_cont_o == e.cont, e.tag, "cont", 64'(rx_cont_o), 64'(e.cont));
         end
      end
   end

   function automatic logic [NB*FW-1:0] ev_on(input int b, input logic [FW-1:0] v);
      logic [NB*FW-1:0] r = '0;
      r[b*FW +: FW] = v;
      return r;
   endfunction

   initial begin
      for (int b = 0; b < NB; b++) begin m_sts[b] = '0; m_en[b] = '0; end
      m_glb = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: reset state
      chk(sts_o == '0 && en_o == '0 && glb_o == '0 && !irq_o && rx_cont_o == '0,
          "R1", "reset", 64'(glb_o), 64'h0);
      rst_n = 1'b1;
      cyc("R1", '0, '0, '0, '0, '0);
      // R3 R10: event with all enables clear is discarded
      cyc("R3", ev_on(0, 16'h0001), '0, '0, '0, '0);
      // R2: enable write stores low 15 bits
      cyc("R2", '0, 4'b0001, '0, 16'hFFFF, '0);
      cyc("R2", '0, '0, '0, '0, '0);
      // R3 R4: ack plus bit 15 event on channel 0
      cyc("R4", ev_on(0, 16'h8001), '0, '0, '0, '0);
      // R2: event same cycle as enable write uses the old enable
      cyc("R2", ev_on(2, 16'h0004), 4'b0100, '0, 16'h0004, '0);
      // R9: channel 2 gets receive-complete, nak is disabled
      cyc("R9", ev_on(2, 16'h0006), '0, '0, '0, '0);
      // R5: clear of zero bits keeps status
      cyc("R5", '0, '0, 4'b0001, 16'h0000, '0);
      // R6: clear leaving zero drops channel 0 summary, line stays for channel 2
      cyc("R6", '0, '0, 4'b0001, 16'h0001, 4'b0100);
      // R8: no pulse without a pending receive
      cyc("R8", '0, '0, 4'b0100, 16'h0004, 4'b0000);
      cyc("R8", ev_on(2, 16'h0004), '0, '0, '0, '0);
      // R8: clear with pending receive pulses continue; R6 line falls
      cyc("R8", '0, '0, 4'b0100, 16'h0004, 4'b0100);
      cyc("R8", '0, '0, '0, '0, 4'b0100);
      // R8: clear of an unset receive flag gives no pulse
      cyc("R8", '0, '0, 4'b0100, 16'h0004, 4'b0100);
      // R7: set and clear of the same bit together
      cyc("R7", ev_on(0, 16'h0002), '0, 4'b0001, 16'h0002, '0);
      // R5: partial clear keeps other bits
      cyc("R5", ev_on(0, 16'h0050), '0, '0, '0, '0);
      cyc("R5", '0, '0, 4'b0001, 16'h0010, '0);
      // R10: narrow the enable then report a disabled event
      cyc("R10", '0, 4'b0001, '0, 16'h0001, '0);
      cyc("R10", ev_on(0, 16'h0010), '0, '0, '0, '0);
      cyc("R10", '0, '0, '0, '0, '0);
      // R6: any clear on an empty channel drops the stale summary bit
      cyc("R6", '0, '0, 4'b0001, 16'h0000, '0);
      // R9: two channels at once, then clear one
      cyc("R9", '0, 4'b1010, '0, 16'h7FFF, '0);
      cyc("R9", ev_on(1, 16'h4000) | ev_on(3, 16'h2008), '0, '0, '0, '0);
      cyc("R9", '0, '0, 4'b0010, 16'hFFFF, '0);
      cyc("R6", '0, '0, 4'b1000, 16'h2008, '0);
      cyc("R1", '0, '0, '0, '0, '0);
      repeat (3) @(negedge clk);
      done = 1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule